// File: doc/BRIEF.md
# Clamp Dwell Guard

This block drives the switch of a voltage clamp that sits on a boost converter's output and keeps that switch from overheating. An analog comparator outside the block raises a request flag whenever the boost output is above the clamp level. The block turns the clamp gate on while that flag is high. It also measures how long the gate has been on, in units of a slow timing tick, across back-to-back fixed windows. The nominal window is one second.

If the gate's total on-time within one window goes over a budget, the block latches a shutdown fault. The budget depends on a line-variant select: the nominal value is 51.2 ms on low line and 76.8 ms on high line. A latched fault turns the clamp off at once and keeps it off, and only a power-on reset clears it. A window that ends without a fault starts the next window from zero. The tick rate, the window length and both budgets are parameters, so a simulation can use short windows.

The control is a three-state machine:
- ST_REST: the gate is off.
- ST_CLAMP: the gate is on.
- ST_TRIP: the fault is latched and the gate is off.

Its transitions are:
- REST→CLAMP when the request is sampled high.
- CLAMP→REST when the request is sampled low.
- CLAMP→TRIP when an on-tick would take the count past the budget. This edge has priority over the return to rest.
- TRIP→TRIP for all inputs, until reset.

Top module: `clamp_dwell_guard`

## Requirements
- R1: While reset is held, and in the first cycle after it, the clamp gate and the fault output are both low, whatever the request input does.
- R2: When no fault is latched, the clamp gate goes high in the cycle after the request is sampled high. It goes low in the cycle after the request is sampled low.
- R3: Each timing tick on which the gate is on adds one to the window's on-time count. A window whose count reaches exactly the budget raises no fault. The tick that would make the count one more than the budget raises the fault, and the fault is visible right after that clock edge.
- R4: With the variant select at 0, the budget is LO_BUDGET ticks. With the variant select at 1, the budget is HI_BUDGET ticks.
- R5: A window lasts WINDOW_TICKS ticks, counted from reset. The last tick of a window still counts toward that window's check. The count is then zero for the next window, so on-time never carries across a window boundary.
- R6: On-time from separate bursts of request within one window adds up.
- R7: In the same cycle that the fault rises, the clamp gate is forced low. It stays low while the fault is latched, even with the request held high.
- R8: Once set, the fault stays high through any input pattern until reset is asserted. Reset then clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low power-on reset, asynchronous assert |
| clamp_req | input | 1 | Comparator flag: the boost output is above the clamp level |
| hi_line | input | 1 | Variant select: 0 for the low-line budget, 1 for the high-line budget |
| clamp_gate | output | 1 | Enable for the clamp switch |
| shut_fault | output | 1 | Latched over-dwell shutdown fault |

## Verification
Two events can fall on the same tick: the window-closing clear and the over-budget trip. They meet when the on-tick that takes the count past the budget is also the last tick of a window. The bench sets this up by starting a held request exactly budget+1 ticks before the window closes. It then expects the fault to be absent one cycle before that final edge and present right after it, which shows that the clear did not hide the overrun. Around this case, the bench also checks that a burst of exactly the budget ending on the boundary, followed by a further full budget, does not trip.

// File: rtl/dwell_pkg.sv
package dwell_pkg;

    typedef enum logic [1:0] {
        ST_REST  = 2'd0,
        ST_CLAMP = 2'd1,
        ST_TRIP  = 2'd2
    } guard_state_e;

    function automatic int unsigned width_for(input int unsigned max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/dwell_tick_gen.sv
module dwell_tick_gen #(
    parameter int unsigned DIV = 5000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int unsigned CW = dwell_pkg::width_for(DIV - 1);

    logic [CW-1:0] div_q;

    assign tick_o = (div_q == CW'(DIV - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (tick_o) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + CW'(1);
        end
    end
endmodule

// File: rtl/dwell_window.sv
module dwell_window #(
    parameter int unsigned TICKS = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    output logic end_o
);
    localparam int unsigned WW = dwell_pkg::width_for(TICKS - 1);

    logic [WW-1:0] pos_q;
    logic          last_w;

    assign last_w = (pos_q == WW'(TICKS - 1));
    assign end_o  = tick_i && last_w;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else if (tick_i) begin
            if (last_w) begin
                pos_q <= '0;
            end else begin
                pos_q <= pos_q + WW'(1);
            end
        end
    end
endmodule

// File: rtl/dwell_accum.sv
module dwell_accum #(
    parameter int unsigned ACC_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             on_i,
    input  logic             clear_i,
    input  logic [ACC_W-1:0] budget_i,
    output logic             over_o,
    output logic [ACC_W-1:0] cnt_o
);
    logic [ACC_W-1:0] cnt_q;
    logic [ACC_W:0]   sum_w;
    logic             full_w;

    assign full_w = &cnt_q;
    assign sum_w  = {1'b0, cnt_q} + (ACC_W + 1)'(1);
    assign over_o = tick_i && on_i && (sum_w > {1'b0, budget_i});
    assign cnt_o  = cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            if (clear_i) begin
                cnt_q <= '0;
            end else if (on_i && !full_w) begin
                cnt_q <= sum_w[ACC_W-1:0];
            end
        end
    end
endmodule

// File: rtl/clamp_dwell_guard.sv
module clamp_dwell_guard #(
    parameter int unsigned TICK_DIV     = 5000,
    parameter int unsigned WINDOW_TICKS = 10000,
    parameter int unsigned LO_BUDGET    = 512,
    parameter int unsigned HI_BUDGET    = 768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clamp_req,
    input  logic hi_line,
    output logic clamp_gate,
    output logic shut_fault
);
    import dwell_pkg::*;

    localparam int unsigned MAX_BUDGET = (LO_BUDGET > HI_BUDGET) ? LO_BUDGET : HI_BUDGET;
    localparam int unsigned ACC_W      = width_for(MAX_BUDGET + 1);

    guard_state_e     state_q;
    guard_state_e     state_nx;
    logic             tick;
    logic             win_end;
    logic             over;
    logic [ACC_W-1:0] acc_cnt;
    logic [ACC_W-1:0] budget_sel;

    assign budget_sel = hi_line ? ACC_W'(HI_BUDGET) : ACC_W'(LO_BUDGET);

    dwell_tick_gen #(.DIV(TICK_DIV)) tick_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    dwell_window #(.TICKS(WINDOW_TICKS)) win_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick),
        .end_o  (win_end)
    );

    dwell_accum #(.ACC_W(ACC_W)) acc_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick),
        .on_i     (state_q == ST_CLAMP),
        .clear_i  (win_end),
        .budget_i (budget_sel),
        .over_o   (over),
        .cnt_o    (acc_cnt)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_REST;
        end else begin
            state_q <= state_nx;
        end
    end

    // Transitions
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_REST:  if (clamp_req) state_nx = ST_CLAMP;
            ST_CLAMP: begin
                if (over) begin
                    state_nx = ST_TRIP;
                end else if (!clamp_req) begin
                    state_nx = ST_REST;
                end
            end
            ST_TRIP:  state_nx = ST_TRIP;
            default:  state_nx = ST_TRIP;
        endcase
    end

    // Outputs
    always_comb begin
        clamp_gate = 1'b0;
        shut_fault = 1'b0;
        unique case (state_q)
            ST_REST:  ;
            ST_CLAMP: clamp_gate = 1'b1;
            ST_TRIP:  shut_fault = 1'b1;
            default:  shut_fault = 1'b1;
        endcase
    end
endmodule

// File: rtl/dwell_guard_chk.sv
module dwell_guard_chk #(
    parameter int unsigned ACC_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clamp_req,
    input logic             clamp_gate,
    input logic             shut_fault,
    input logic             win_end,
    input logic [ACC_W-1:0] acc_cnt,
    input logic [ACC_W-1:0] budget_sel
);
    p_gate_off_in_fault_r7: assert property (@(posedge clk) disable iff (!rst_n)
        shut_fault |-> !clamp_gate);

    p_fault_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        shut_fault |=> shut_fault);

    p_gate_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clamp_gate) |-> $past(clamp_req));

    p_gate_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (clamp_req && !shut_fault) |=> (clamp_gate || shut_fault));

    p_trip_from_clamp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shut_fault) |-> $past(clamp_gate));

    p_count_bounded_r3: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, acc_cnt} <= {1'b0, budget_sel} + (ACC_W + 1)'(1));

    p_window_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        win_end |=> (acc_cnt == '0));
endmodule

bind clamp_dwell_guard dwell_guard_chk #(.ACC_W(ACC_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .clamp_req  (clamp_req),
    .clamp_gate (clamp_gate),
    .shut_fault (shut_fault),
    .win_end    (win_end),
    .acc_cnt    (acc_cnt),
    .budget_sel (budget_sel)
);

// File: tb/clamp_dwell_guard_tb_top.sv
`timescale 1ns/1ps
module clamp_dwell_guard_tb_top;
    localparam int unsigned TB_DIV = 4;
    localparam int unsigned TB_WIN = 32;
    localparam int unsigned TB_LO  = 6;
    localparam int unsigned TB_HI  = 9;
    localparam int unsigned WIN_EDGES = TB_DIV * TB_WIN;

    // {hi_line, expect_fault, on_ticks[7:0]}
    localparam int NV = 8;
    localparam logic [9:0] VTAB [NV] = '{
        {1'b0, 1'b0, 8'd0},
        {1'b0, 1'b0, 8'd6},
        {1'b0, 1'b1, 8'd7},
        {1'b1, 1'b0, 8'd9},
        {1'b1, 1'b1, 8'd10},
        {1'b1, 1'b0, 8'd7},
        {1'b0, 1'b1, 8'd9},
        {1'b1, 1'b1, 8'd20}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clamp_req = 1'b0;
    logic hi_line = 1'b0;
    logic clamp_gate;
    logic shut_fault;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    clamp_dwell_guard #(
        .TICK_DIV(TB_DIV), .WINDOW_TICKS(TB_WIN),
        .LO_BUDGET(TB_LO), .HI_BUDGET(TB_HI)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .clamp_req(clamp_req), .hi_line(hi_line),
        .clamp_gate(clamp_gate), .shut_fault(shut_fault)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Reset; returns just after release, aligned to a window start.
    task automatic do_reset(input logic hl);
        clamp_req = 1'b0;
        hi_line = hl;
        rst_n = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
    endtask

    // Gate on for exactly n ticks; consumes TB_DIV*(n+1) edges.
    task automatic burst(input int n);
        clamp_req = 1'b1;
        repeat (TB_DIV * n + 1) step();
        clamp_req = 1'b0;
        repeat (TB_DIV - 1) step();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        // R1: reset state with request held high
        clamp_req = 1'b1;
        repeat (3) step();
        chk("R1 gate in reset", clamp_gate, 1'b0);
        chk("R1 fault in reset", shut_fault, 1'b0);
        do_reset(1'b0);
        chk("R1 gate after release", clamp_gate, 1'b0);
        chk("R1 fault after release", shut_fault, 1'b0);

        // R2: gate follows request one cycle later
        clamp_req = 1'b1;
        step();
        chk("R2 gate on", clamp_gate, 1'b1);
        clamp_req = 1'b0;
        step();
        chk("R2 gate off", clamp_gate, 1'b0);

        // Table: one window per entry (R3, R4)
        for (int i = 0; i < NV; i++) begin
            do_reset(VTAB[i][9]);
            burst(int'(VTAB[i][7:0]));
            repeat (WIN_EDGES - TB_DIV * (int'(VTAB[i][7:0]) + 1)) step();
            chk($sformatf("R3 R4 vector %0d", i), shut_fault, VTAB[i][8]);
        end

        // R3 R7: exact trip cycle on low line (7th tick at edge 28)
        do_reset(1'b0);
        clamp_req = 1'b1;
        repeat (27) step();
        chk("R3 no fault before over tick", shut_fault, 1'b0);
        chk("R7 gate on before trip", clamp_gate, 1'b1);
        step();
        chk("R3 fault on over tick", shut_fault, 1'b1);
        chk("R7 gate forced off with trip", clamp_gate, 1'b0);
        repeat (200) step();
        chk("R7 gate stays off under request", clamp_gate, 1'b0);
        chk("R8 fault holds", shut_fault, 1'b1);
        clamp_req = 1'b0;
        repeat (300) step();
        chk("R8 fault holds after windows pass", shut_fault, 1'b1);
        do_reset(1'b0);
        chk("R8 reset clears fault", shut_fault, 1'b0);

        // R6: two bursts in one window add up (3 + 4 > 6)
        burst(3);
        burst(4);
        chk("R6 bursts accumulate", shut_fault, 1'b1);

        // R5: budget ending on boundary, then full budget next window
        do_reset(1'b0);
        repeat (WIN_EDGES - TB_DIV * (TB_LO + 1)) step();
        burst(TB_LO);
        burst(TB_LO);
        chk("R5 count cleared at boundary", shut_fault, 1'b0);
        burst(1);
        chk("R5 next window still trips past budget", shut_fault, 1'b1);

        // R5: over tick coincides with window end tick
        do_reset(1'b0);
        repeat (WIN_EDGES - TB_DIV * (TB_LO + 1)) step();
        clamp_req = 1'b1;
        repeat (TB_DIV * (TB_LO + 1) - 1) step();
        chk("R5 no fault before last tick", shut_fault, 1'b0);
        step();
        chk("R5 last tick of window trips", shut_fault, 1'b1);
        clamp_req = 1'b0;

        // R4: high line tolerates what trips low line
        do_reset(1'b1);
        burst(TB_LO + 1);
        burst(TB_HI - TB_LO - 1);
        chk("R4 high line at budget", shut_fault, 1'b0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule